// File: doc/BRIEF.md
# SMBus Send/Receive Byte Slave

This block is a small SMBus slave for a fan-speed or regulator controller. It answers at one fixed 7-bit address and understands two transfers only. In a send byte, the host writes one command byte that holds a 6-bit output code and a boost-enable flag. In a receive byte, the host reads one status byte that holds an overcurrent flag and a thermal-shutdown flag. The block works from a system clock that runs at least ten times faster than SCL. Both bus lines pass through a synchronizer, and the block drives SDA only through a pull-down enable, which an open-drain pad turns into a wired-AND line.

The new command takes effect only at the falling SCL edge that ends the acknowledge of the command byte. The command register changes in that cycle and a one-cycle write strobe fires with it. If a stop or a fresh start comes before that edge, the register keeps its old value. The status flags come in on their own inputs and are registered once per clock. They are sent most significant bit first.

Top module: `smb_byte_slave`

## Requirements
- R1: After the asynchronous reset, code_o is 0, boost_o is 0, sda_pd_o is 0 and wr_stb_o is 0. A reset in the middle of operation returns the command register to 0.
- R2: When the first byte after a start is 0xE8 (address 1110100, R/W = 0), the slave pulls SDA low during the ninth SCL clock. It also pulls SDA low during the ninth clock of the command byte that follows.
- R3: Command byte bits 5..0 become code_o, with bit 5 as the MSB. Bit 6 becomes boost_o. Bit 7 has no effect.
- R4: Each completed send byte gives exactly one wr_stb_o pulse of one cycle, even when the value written equals the value already held. code_o and boost_o change in that same cycle and at no other time.
- R5: A stop that arrives before the command byte has been acknowledged leaves code_o and boost_o unchanged and gives no strobe.
- R6: When the address byte does not match, the slave does not acknowledge it. It then ignores every later byte, including 0xE8, and drives nothing until the next start.
- R7: When the first byte is 0xE9 (R/W = 1), the slave acknowledges and then sends the byte {ocf, thm, 000000}, MSB first, each bit changed while SCL is low. It releases SDA for the host's acknowledge bit.
- R8: A repeated start in the middle of a byte resets the bit counter and restarts address reception. A full send byte that follows it commits normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 10x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on / undervoltage) |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level (wired-AND bus) |
| sda_pd_o | output | 1 | SDA pull-down enable, 1 drives the line low |
| ocf_i | input | 1 | Overcurrent flag, sent as status bit 7 |
| thm_i | input | 1 | Thermal-shutdown flag, sent as status bit 6 |
| code_o | output | CODE_W | Committed output code |
| boost_o | output | 1 | Committed boost-start enable |
| wr_stb_o | output | 1 | One-cycle strobe on each command commit |

## Verification
The bench builds the block with its default parameters: address 0x74, a 6-bit code and a two-stage synchronizer. SCL phases last eight system clocks. That is long enough for the three-cycle synchronizer and edge-detect latency to settle before each host sample, and it makes the slave's own SDA changes land while SCL is low. A behavioural model in the bench tracks the expected command value and compares it with the outputs on every clock. It allows a change only at the strobe that closes a send byte. This brings within reach aborted transfers, mismatched addresses, repeated starts and status readback with each flag pattern.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_TX,
    ST_HACK,
    ST_WAIT
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h74,
  parameter int unsigned KEEP_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              pd_o,
  output logic              commit_o,
  output logic [KEEP_W-1:0] cmd_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  smb_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              pd_q;
  logic              commit_q;
  logic              start_c;
  logic              stop_c;

  assign start_c = scl_lvl_i & sda_fall_i;
  assign stop_c  = scl_lvl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      pd_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_c) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pd_q    <= 1'b0;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
        pd_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (state_q == ST_CMD) begin
                state_q <= ST_CACK;
                pd_q    <= 1'b1;
              end else if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                state_q <= ST_AACK;
                pd_q    <= 1'b1;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rx_q[0]) begin
                state_q <= ST_TX;
                tx_q    <= status_i;
                pd_q    <= ~status_i[BYTE_W-1];
              end else begin
                state_q <= ST_CMD;
                pd_q    <= 1'b0;
              end
            end
          end
          ST_CACK: begin
            // commit exactly at the falling edge that ends the acknowledge
            if (scl_fall_i) begin
              pd_q     <= 1'b0;
              commit_q <= 1'b1;
              state_q  <= ST_WAIT;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == CNT_FULL) begin
                state_q <= ST_HACK;
                pd_q    <= 1'b0;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                pd_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_HACK: begin
            if (scl_fall_i) state_q <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  assign pd_o     = pd_q;
  assign commit_o = commit_q;
  assign cmd_o    = rx_q[KEEP_W-1:0];

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_c |=> (state_q == ST_ADDR) && (cnt_q == '0) && !pd_q);

  assert_stop_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_c && !start_c) |=> (state_q == ST_IDLE) && !pd_q && !commit_q);

  assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_WAIT || state_q == ST_ADDR || state_q == ST_CMD)
      |-> !pd_q);

  assert_commit_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> ($past(state_q) == ST_CACK) && (state_q == ST_WAIT));
endmodule

// File: rtl/smb_cmd_reg.sv
module smb_cmd_reg #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [CODE_W:0]   byte_i,
  output logic [CODE_W-1:0] code_o,
  output logic              boost_o,
  output logic              stb_o
);
  localparam int unsigned BOOST_BIT = CODE_W;

  logic [CODE_W-1:0] code_q;
  logic              boost_q;
  logic              stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      boost_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= commit_i;
      if (commit_i) begin
        code_q  <= byte_i[CODE_W-1:0];
        boost_q <= byte_i[BOOST_BIT];
      end
    end
  end

  assign code_o  = code_q;
  assign boost_o = boost_q;
  assign stb_o   = stb_q;

  assert_stb_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({boost_q, code_q}) |-> stb_q);
endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h74,
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  input  logic              ocf_i,
  input  logic              thm_i,
  output logic [CODE_W-1:0] code_o,
  output logic              boost_o,
  output logic              wr_stb_o
);
  localparam int unsigned KEEP_W  = CODE_W + 1;
  localparam int unsigned LINES   = 2;
  localparam int unsigned L_SDA   = 0;
  localparam int unsigned L_SCL   = 1;
  localparam int unsigned FLAGS_W = 2;

  logic [LINES-1:0]  raw, lvl, rise, fall;
  logic [FLAGS_W-1:0] status_q;
  logic [BYTE_W-1:0]  status_byte;
  logic               commit;
  logic [KEEP_W-1:0]  cmd_byte;

  assign raw[L_SDA] = sda_i;
  assign raw[L_SCL] = scl_i;

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (raw[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= {ocf_i, thm_i};
  end

  assign status_byte = {status_q, {(BYTE_W-FLAGS_W){1'b0}}};

  smb_bit_engine #(.DEV_ADDR(DEV_ADDR), .KEEP_W(KEEP_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[L_SCL]),
    .scl_rise_i (rise[L_SCL]),
    .scl_fall_i (fall[L_SCL]),
    .sda_lvl_i  (lvl[L_SDA]),
    .sda_rise_i (rise[L_SDA]),
    .sda_fall_i (fall[L_SDA]),
    .status_i   (status_byte),
    .pd_o       (sda_pd_o),
    .commit_o   (commit),
    .cmd_o      (cmd_byte)
  );

  smb_cmd_reg #(.CODE_W(CODE_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .byte_i   (cmd_byte),
    .code_o   (code_o),
    .boost_o  (boost_o),
    .stb_o    (wr_stb_o)
  );

  assert_ack_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !lvl[L_SCL]);
endmodule

// File: tb/smb_byte_slave_bench.sv
module smb_byte_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic ocf = 1'b0;
  logic thm = 1'b0;
  logic sda_pd;
  logic [5:0] code;
  logic boost;
  logic wr_stb;
  logic sda_bus;

  always #4 clk = ~clk;

  assign sda_bus = sda_host & ~sda_pd;

  smb_byte_slave u_smb_byte_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_pd_o (sda_pd),
    .ocf_i    (ocf),
    .thm_i    (thm),
    .code_o   (code),
    .boost_o  (boost),
    .wr_stb_o (wr_stb)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: expected command value, changes only at a strobe
  int exp_code = 0, exp_boost = 0, nxt_code = 0, nxt_boost = 0;
  bit pending = 1'b0;
  int strobes = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_code = 0; exp_boost = 0; pending = 1'b0;
    end else begin
      if (wr_stb) begin
        strobes++;
        if (pending) begin
          exp_code = nxt_code; exp_boost = nxt_boost; pending = 1'b0;
        end else chk(1'b0, "R5 strobe without completed send byte", 1, 0);
      end
      if (!pending)
        chk(int'(code) == exp_code && int'(boost) == exp_boost, "R3 per-clock command compare",
            int'({boost, code}), (exp_boost << 6) | exp_code);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_host = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_host = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_host = 1'b1; tick(Q);
  endtask

  task automatic wbit(input bit b);
    sda_host = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output bit b);
    sda_host = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    acked = !b;
  endtask

  task automatic rbyte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(1'b1);  // host NACK
  endtask

  task automatic write_cmd(input logic [7:0] cmd);
    bit a;
    int s0;
    bus_start();
    wbyte(8'hE8, a);
    chk(a, "R2 address acknowledge", a, 1);
    s0 = strobes;
    nxt_code = int'(cmd[5:0]);
    nxt_boost = int'(cmd[6]);
    pending = 1'b1;
    wbyte(cmd, a);
    chk(a, "R2 command acknowledge", a, 1);
    bus_stop();
    tick(4);
    chk(strobes == s0 + 1, "R4 one strobe per send byte", strobes - s0, 1);
    chk(int'(code) == int'(cmd[5:0]), "R3 code field", code, cmd[5:0]);
    chk(boost == cmd[6], "R3 boost bit", boost, cmd[6]);
  endtask

  task automatic read_status(input bit o, input bit t);
    bit a;
    logic [7:0] v;
    ocf = o; thm = t;
    tick(4);
    bus_start();
    wbyte(8'hE9, a);
    chk(a, "R7 read address acknowledge", a, 1);
    rbyte(v);
    bus_stop();
    chk(v == {o, t, 6'b0}, "R7 status byte", v, {o, t, 6'b0});
    chk(!sda_pd, "R7 SDA released after read", sda_pd, 0);
  endtask

  initial begin
    bit a;
    int s0;
    tick(3);
    chk(code == 6'd0, "R1 reset code", code, 0);
    chk(!boost, "R1 reset boost", boost, 0);
    chk(!sda_pd, "R1 reset pull-down", sda_pd, 0);
    chk(!wr_stb, "R1 reset strobe", wr_stb, 0);
    rst_n = 1'b1;
    tick(5);

    write_cmd(8'h15);
    write_cmd(8'h55);
    write_cmd(8'hBF);  // R3: bit 7 ignored
    write_cmd(8'hBF);  // R4: same value still strobes

    // R5: stop in the middle of the command byte
    s0 = strobes;
    bus_start();
    wbyte(8'hE8, a);
    chk(a, "R5 address acked before abort", a, 1);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    bus_stop();
    tick(4);
    chk(strobes == s0, "R5 no strobe after early stop", strobes - s0, 0);
    chk(code == 6'h3F && !boost, "R5 command kept", {boost, code}, 8'h3F);

    // R5: stop right after the address acknowledge
    bus_start();
    wbyte(8'hE8, a);
    bus_stop();
    tick(4);
    chk(strobes == s0, "R5 no strobe after stop at command start", strobes - s0, 0);

    // R6: wrong address, later bytes ignored
    bus_start();
    wbyte(8'hD0, a);
    chk(!a, "R6 no ack for wrong address", a, 0);
    wbyte(8'hE8, a);
    chk(!a, "R6 ignored byte not acked", a, 0);
    wbyte(8'h00, a);
    chk(!a, "R6 second ignored byte not acked", a, 0);
    bus_stop();
    bus_start();
    wbyte(8'hEA, a);
    chk(!a, "R6 neighbour address not acked", a, 0);
    bus_stop();
    tick(4);
    chk(strobes == s0, "R6 no strobe from ignored transfer", strobes - s0, 0);

    // R8: repeated start mid-byte
    bus_start();
    wbyte(8'hE8, a);
    for (int i = 0; i < 3; i++) wbit(1'b1);
    bus_start();
    wbyte(8'hE8, a);
    chk(a, "R8 address acked after repeated start", a, 1);
    nxt_code = 'h2A; nxt_boost = 0; pending = 1'b1;
    wbyte(8'h2A, a);
    chk(a, "R8 command acked after repeated start", a, 1);
    bus_stop();
    tick(4);
    chk(strobes == s0 + 1, "R8 commit after repeated start", strobes - s0, 1);
    chk(code == 6'h2A, "R8 code after repeated start", code, 8'h2A);

    read_status(1'b1, 1'b0);
    read_status(1'b0, 1'b1);
    read_status(1'b1, 1'b1);
    read_status(1'b0, 1'b0);
    chk(code == 6'h2A, "R7 read leaves command alone", code, 8'h2A);

    // R1: reset during operation
    write_cmd(8'h7F);
    rst_n = 1'b0;
    tick(2);
    chk(code == 6'd0 && !boost, "R1 reset clears command", {boost, code}, 0);
    rst_n = 1'b1;
    tick(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule